// File: doc/BRIEF.md
# Watchdog and Software Reset Controller

This block guards a processor against a stalled program. A free-running counter climbs while the watchdog is enabled. If software does not restart it in time, the block drives an internal reset pulse of fixed length. Software restarts the counter by writing a two-byte key, in order, to a byte-wide key register. A second two-byte key written to the same register asks for an immediate reset of the same length. Two sticky flags record which of the two causes produced the last reset. They keep their value through the block's own pulse, so the code that runs after the reset can read them.

The timeout period is picked by a 3-bit select as 2^(TMO_BASE+sel) clock cycles, with TMO_BASE = 14 by default. When the processor is idle, a separate enable decides whether the counter keeps running or holds its value. A write port with a one-bit register select reaches either the key register or the flag register.

Top module: `wdt_rst_ctrl`

## Requirements
- R1: After the external reset `rstN` is released, `rstPulse`, `flagOvf` and `flagSw` are all 0.
- R2: While `wdtEnable` is 1 and the counter is running, `rstPulse` rises after exactly 2^(TMO_BASE+`tmoSel`) running clock edges, counted from enable, refresh or the end of the previous pulse. While `wdtEnable` is 0 the count is held at zero and no timeout occurs.
- R3: Every internal reset pulse holds `rstPulse` at 1 for exactly PULSE_LEN (16) cycles. While the pulse lasts, the counter is held at zero and key writes are ignored.
- R4: A timeout sets `flagOvf` and leaves `flagSw` unchanged.
- R5: A key-register write (`wrSel`=0) of 0x1E followed by a write of 0xE1 restarts the count from zero. If the second byte lands on the cycle that would otherwise time out, the refresh wins and no pulse starts.
- R6: A key-register write of 0x5A followed by a write of 0xA5 starts the reset pulse on the edge of the second write and sets `flagSw`.
- R7: Once a first key byte is held, any other key write clears the held state and takes no action. This includes a wrong second byte and a repeated first byte.
- R8: The flags survive the pulse the block produces. A flag-register write (`wrSel`=1) clears `flagOvf` when bit 0 is 0 and clears `flagSw` when bit 1 is 0. Writing 1 to either bit leaves that flag unchanged.
- R9: While `idleIn` is 1 and `idleRunEn` is 0, the counter holds its value and resumes from it afterwards. With `idleRunEn` at 1, the counter keeps running during idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low external reset; clears everything, flags included |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Register select: 0 key register, 1 flag register |
| wrData | input | 8 | Write data |
| wdtEnable | input | 1 | Watchdog counter enable |
| tmoSel | input | 3 | Timeout select n, period 2^(TMO_BASE+n) cycles |
| idleIn | input | 1 | Processor is idle |
| idleRunEn | input | 1 | Keep the watchdog running during idle |
| rstPulse | output | 1 | Internal reset pulse |
| flagOvf | output | 1 | Last reset came from a watchdog timeout |
| flagSw | output | 1 | Last reset came from a software request |

## Verification
The hardest case to reach from the ports is a refresh whose second key byte arrives on the very edge at which the count would time out. The bench builds a small configuration (TMO_BASE = 4). It counts the edges after enable so that the first key byte pushes the count to its last value, then writes the second byte on the next edge. In the same way it interleaves broken key sequences, idle pauses and disable gaps with running counts. The observed timeout has to equal the arithmetic remainder of the period. The bench also sweeps every timeout select and measures both the period and the pulse width.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Key bytes: the order within each pair is behaviour
  localparam logic [7:0] RefKeyA = 8'h1E;
  localparam logic [7:0] RefKeyB = 8'hE1;
  localparam logic [7:0] SwKeyA  = 8'h5A;
  localparam logic [7:0] SwKeyB  = 8'hA5;

  typedef enum logic [1:0] {
    KEY_IDLE,
    KEY_REF,
    KEY_SWR
  } keyState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic refresh;
    logic swReset;
    logic hold;
    logic clrOvf;
    logic clrSw;
  } wdtStrb_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int PULSE_LEN = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       wrSel,
  input  logic [7:0] wrData,
  input  logic       tmoHit,
  output wdtStrb_t   strb,
  output logic       rstPulse
);
  localparam int PCNT_W = $clog2(PULSE_LEN + 1);

  keyState_t        keySt, keyNext;
  logic [PCNT_W-1:0] pulseCnt;
  logic             busy;
  logic             keyWr;
  logic             load;

  assign busy  = (pulseCnt != '0);
  assign keyWr = wrEn && !wrSel && !busy;

  always_comb begin
    keyNext = keySt;
    if (busy) begin
      keyNext = KEY_IDLE;
    end else if (keyWr) begin
      unique case (keySt)
        KEY_IDLE: begin
          if (wrData == RefKeyA)     keyNext = KEY_REF;
          else if (wrData == SwKeyA) keyNext = KEY_SWR;
          else                       keyNext = KEY_IDLE;
        end
        default: keyNext = KEY_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.refresh = keyWr && (keySt == KEY_REF) && (wrData == RefKeyB);
    strb.swReset = keyWr && (keySt == KEY_SWR) && (wrData == SwKeyB);
    strb.hold    = busy;
    strb.clrOvf  = wrEn && wrSel && !wrData[0];
    strb.clrSw   = wrEn && wrSel && !wrData[1];
  end

  assign load = tmoHit || strb.swReset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keySt    <= KEY_IDLE;
      pulseCnt <= '0;
    end else begin
      keySt <= keyNext;
      if (load)      pulseCnt <= PCNT_W'(PULSE_LEN);
      else if (busy) pulseCnt <= pulseCnt - PCNT_W'(1);
    end
  end

  assign rstPulse = busy;

  // R3
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !load) |=> (pulseCnt == $past(pulseCnt) - PCNT_W'(1)));
  // R3
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstPulse) |-> (pulseCnt == PCNT_W'(PULSE_LEN)));
  // R7
  key_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (keyWr && keySt != KEY_IDLE) |=> (keySt == KEY_IDLE));
endmodule

// File: rtl/wdt_dp.sv
module wdt_dp
  import wdt_pkg::*;
#(
  parameter int TMO_BASE = 14,
  parameter int SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdtStrb_t         strb,
  input  logic             wdtEnable,
  input  logic [SEL_W-1:0] tmoSel,
  input  logic             idleIn,
  input  logic             idleRunEn,
  output logic             tmoHit,
  output logic             flagOvf,
  output logic             flagSw
);
  localparam int CNT_W = TMO_BASE + (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntLimit;
  logic             run;

  assign cntLimit = (CNT_W'(1) << (TMO_BASE + int'(tmoSel))) - CNT_W'(1);
  assign run      = wdtEnable && !strb.hold && !(idleIn && !idleRunEn);
  assign tmoHit   = run && !strb.refresh && (cnt >= cntLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (!wdtEnable || strb.hold || strb.refresh || tmoHit) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagOvf <= 1'b0;
      flagSw  <= 1'b0;
    end else begin
      if (tmoHit)           flagOvf <= 1'b1;
      else if (strb.clrOvf) flagOvf <= 1'b0;
      if (strb.swReset)     flagSw  <= 1'b1;
      else if (strb.clrSw)  flagSw  <= 1'b0;
    end
  end

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wdtEnable |=> (cnt == '0) && !tmoHit);
  // R4
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagOvf) |-> $past(tmoHit));
  // R6
  sw_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagSw) |-> $past(strb.swReset));
  // R8
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagOvf && !strb.clrOvf) |=> flagOvf);
  // R9
  idle_pause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wdtEnable && idleIn && !idleRunEn && !strb.hold && !strb.refresh) |=> $stable(cnt));
endmodule

// File: rtl/wdt_rst_ctrl.sv
module wdt_rst_ctrl
  import wdt_pkg::*;
#(
  parameter int TMO_BASE  = 14,
  parameter int SEL_W     = 3,
  parameter int PULSE_LEN = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [7:0]       wrData,
  input  logic             wdtEnable,
  input  logic [SEL_W-1:0] tmoSel,
  input  logic             idleIn,
  input  logic             idleRunEn,
  output logic             rstPulse,
  output logic             flagOvf,
  output logic             flagSw
);
  wdtStrb_t strb;
  logic     tmoHit;

  wdt_ctrl #(.PULSE_LEN(PULSE_LEN)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrSel   (wrSel),
    .wrData  (wrData),
    .tmoHit  (tmoHit),
    .strb    (strb),
    .rstPulse(rstPulse)
  );

  wdt_dp #(.TMO_BASE(TMO_BASE), .SEL_W(SEL_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wdtEnable(wdtEnable),
    .tmoSel   (tmoSel),
    .idleIn   (idleIn),
    .idleRunEn(idleRunEn),
    .tmoHit   (tmoHit),
    .flagOvf  (flagOvf),
    .flagSw   (flagSw)
  );
endmodule

// File: tb/test_wdt_rst_ctrl.sv
module test_wdt_rst_ctrl;
  localparam int BASE = 4;
  localparam int PLEN = 16;

  logic       clk = 1'b0;
  logic       rstN, wrEn, wrSel, wdtEnable, idleIn, idleRunEn;
  logic [7:0] wrData;
  logic [2:0] tmoSel;
  logic       rstPulse, flagOvf, flagSw;
  int         nRun = 0;
  int         nFail = 0;

  always #2 clk = ~clk;

  wdt_rst_ctrl #(.TMO_BASE(BASE), .SEL_W(3), .PULSE_LEN(PLEN)) i_wdt_rst_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .wdtEnable(wdtEnable), .tmoSel(tmoSel), .idleIn(idleIn), .idleRunEn(idleRunEn),
    .rstPulse(rstPulse), .flagOvf(flagOvf), .flagSw(flagSw)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic regWrite(input logic sel, input logic [7:0] b);
    wrEn = 1'b1; wrSel = sel; wrData = b;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic measureTmo(output int k);
    k = 0;
    do begin
      tick();
      k++;
    end while (!rstPulse && k < 5000);
  endtask

  task automatic measureWidth(output int w);
    w = 0;
    while (rstPulse && w < 100) begin
      w++;
      tick();
    end
  endtask

  task automatic restart();
    wdtEnable = 1'b0;
    tick();
    wdtEnable = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int k, w, p;
    bit seen;
    rstN = 1'b0; wrEn = 1'b0; wrSel = 1'b0; wrData = '0;
    wdtEnable = 1'b0; tmoSel = '0; idleIn = 1'b0; idleRunEn = 1'b0;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    chk(!rstPulse && !flagOvf && !flagSw, "R1", {rstPulse, flagOvf, flagSw}, 0);

    // R2 disabled watchdog never times out
    seen = 0;
    for (int i = 0; i < 3000; i++) begin tick(); if (rstPulse) seen = 1; end
    chk(!seen, "R2 disabled", seen, 0);

    // Sweep every select: period, pulse width, flag cause
    for (int s = 0; s < 8; s++) begin
      tmoSel = 3'(s);
      regWrite(1'b1, 8'h00);
      wdtEnable = 1'b1;
      measureTmo(k);
      chk(k == (1 << (BASE + s)), "R2 period", k, 1 << (BASE + s));
      chk(flagOvf && !flagSw, "R4", {flagOvf, flagSw}, 2);
      measureWidth(w);
      chk(w == PLEN, "R3 width", w, PLEN);
      chk(flagOvf == 1'b1, "R8 survive", flagOvf, 1);
      wdtEnable = 1'b0;
      tick();
    end

    // R2 restart after the pulse
    tmoSel = 3'd0; p = 1 << BASE;
    wdtEnable = 1'b1;
    measureTmo(k); measureWidth(w);
    measureTmo(k);
    chk(k == p, "R2 after pulse", k, p);
    measureWidth(w);

    // R8 flag clear rules
    regWrite(1'b1, 8'h03);
    chk(flagOvf == 1'b1, "R8 write one", flagOvf, 1);
    regWrite(1'b1, 8'h02);
    chk(flagOvf == 1'b0, "R8 clear ovf", flagOvf, 0);

    // R2 count cleared while disabled
    tmoSel = 3'd1; p = 1 << (BASE + 1);
    restart();
    repeat (20) tick();
    restart();
    measureTmo(k);
    chk(k == p, "R2 disable clears", k, p);
    measureWidth(w);

    // R5 refresh on the last cycle before timeout
    restart();
    repeat (p - 2) tick();
    regWrite(1'b0, 8'h1E);
    regWrite(1'b0, 8'hE1);
    chk(!rstPulse, "R5 refresh wins", rstPulse, 0);
    measureTmo(k);
    chk(k == p, "R5 restart", k, p);
    measureWidth(w);

    // R7 wrong second byte
    restart();
    regWrite(1'b0, 8'h1E); regWrite(1'b0, 8'h00); regWrite(1'b0, 8'hE1);
    measureTmo(k);
    chk(k == p - 3, "R7 wrong byte", k, p - 3);
    measureWidth(w);
    // R7 repeated first byte
    restart();
    regWrite(1'b0, 8'h1E); regWrite(1'b0, 8'h1E); regWrite(1'b0, 8'hE1);
    measureTmo(k);
    chk(k == p - 3, "R7 repeat byte", k, p - 3);
    measureWidth(w);

    // R6 software reset
    wdtEnable = 1'b0;
    regWrite(1'b1, 8'h00);
    regWrite(1'b0, 8'h5A); regWrite(1'b0, 8'hA5);
    chk(rstPulse == 1'b1, "R6 pulse", rstPulse, 1);
    chk(flagSw && !flagOvf, "R6 flag", {flagOvf, flagSw}, 1);
    measureWidth(w);
    chk(w == PLEN, "R3 sw width", w, PLEN);
    chk(flagSw == 1'b1, "R8 sw survive", flagSw, 1);
    regWrite(1'b1, 8'h01);
    chk(flagSw == 1'b0, "R8 clear sw", flagSw, 0);

    // R7 broken software key sequences
    regWrite(1'b0, 8'h5A); regWrite(1'b0, 8'h5A); regWrite(1'b0, 8'hA5);
    chk(!rstPulse && !flagSw, "R7 sw repeat", {rstPulse, flagSw}, 0);
    regWrite(1'b0, 8'h5A); regWrite(1'b0, 8'hE1); regWrite(1'b0, 8'hA5);
    chk(!rstPulse && !flagSw, "R7 sw wrong", {rstPulse, flagSw}, 0);

    // R9 idle pause holds the count
    tmoSel = 3'd0; p = 1 << BASE;
    restart();
    repeat (5) tick();
    idleIn = 1'b1; idleRunEn = 1'b0;
    seen = 0;
    for (int i = 0; i < 40; i++) begin tick(); if (rstPulse) seen = 1; end
    chk(!seen, "R9 paused", seen, 0);
    idleIn = 1'b0;
    measureTmo(k);
    chk(k == p - 5, "R9 resume", k, p - 5);
    measureWidth(w);
    // R9 running during idle
    idleIn = 1'b1; idleRunEn = 1'b1;
    restart();
    measureTmo(k);
    chk(k == p, "R9 idle run", k, p);
    measureWidth(w);
    idleIn = 1'b0;

    // R1 external reset clears flags
    rstN = 1'b0; tick(); rstN = 1'b1; tick();
    chk(!flagOvf && !flagSw && !rstPulse, "R1 flags cleared", {rstPulse, flagOvf, flagSw}, 0);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule